// File: doc/BRIEF.md
# XTS Ciphertext-Stealing Tail Controller

This block sequences one XTS message of at least 16 bytes through an external tweaked block-cipher engine. The length need not be a multiple of 16. A start pulse latches the length and the direction. The controller then pulls 16-byte words from a source, sends each word to the engine with the matching tweak, and emits the results as 16-byte output words with byte enables. The engine does the cipher rounds. A separate generator supplies the tweaks: it presents the current tweak and the one after it, and steps forward on request.

When the length leaves a remainder of 1 to 15 bytes, the controller runs ciphertext stealing on the tail. The result of the last full block is kept back. Its low bytes become the short final output. The partial input bytes replace those low bytes, and the merged word goes through the engine once more. Encryption and decryption apply the last two tweaks in opposite orders. All input words, the partial one included, are read before any tail output is written, so the source and destination may share storage.

The source word with index i holds message bytes 16i to 16i+15, with byte j in bits [8j+7:8j]. The output word order matches this layout. A message whose length is a multiple of 16 leaves the tweak generator pointing at the tweak for the next block. Only the final segment of a multi-part message may end in a partial block.

Top module: `xts_cts_ctrl`

## Requirements
- R1: A `start` in the idle state latches `msg_len` and `decrypt`. `in_ready` is high only while a word is being fetched. The block accepts exactly m = len/16 full words, plus one more word when the remainder r = len mod 16 is non-zero. `msg_len` is at least 16 at start.
- R2: Each fetched word is offered on `eng_req` with `eng_enc` = not `decrypt`. Data and tweak stay stable until `eng_req_rdy` is seen. No new request is raised until `eng_rsp_vld` returns, so at most one request is outstanding.
- R3: With r = 0, full word i is processed with tweak T(i) and output in order with `out_be` all ones. `done` is raised with the last output word.
- R4: When encrypting with r > 0, word m-1 uses T(m-1) and its result C is held. The merged word has bytes j < r from the partial input and bytes j >= r from C. It is processed with T(m) and output as the full word at position m-1.
- R5: When decrypting with r > 0, word m-1 uses the later tweak T(m), taken from `tw_nxt`. The merged word uses the earlier tweak T(m-1), taken from `tw_cur`, with no step in between. Decrypting the output of R4 gives back the plaintext.
- R6: With r > 0 the block emits m+1 output words. The last one carries the held bytes with only the low r bits of `out_be` set. It follows the merged full word in the very next cycle, together with `done`.
- R7: The partial input word is accepted before the first tail output word appears.
- R8: `tw_adv` pulses once per engine response that moves the tweak forward. This gives m pulses for encryption or for r = 0, and m-1 pulses for decryption with r > 0.
- R9: A `start` that arrives while a message is in progress is ignored and does not change the result.
- R10: After reset the block is idle, and `in_ready`, `eng_req`, `out_valid`, `done` and `tw_adv` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a message (idle only) |
| msg_len | input | LEN_W | Message length in bytes, at least 16 |
| decrypt | input | 1 | 1 = decrypt, 0 = encrypt |
| in_valid | input | 1 | Source word valid |
| in_ready | output | 1 | Source word accepted when both are high |
| in_data | input | BLK_BYTES*8 | Source word, byte j in bits [8j+7:8j] |
| eng_req | output | 1 | Engine request valid |
| eng_req_rdy | input | 1 | Engine takes the request |
| eng_data | output | BLK_BYTES*8 | Word sent to the engine |
| eng_tweak | output | BLK_BYTES*8 | Tweak for this request |
| eng_enc | output | 1 | 1 = encrypt request |
| eng_rsp_vld | input | 1 | Engine result valid |
| eng_rsp_data | input | BLK_BYTES*8 | Engine result |
| tw_cur | input | BLK_BYTES*8 | Current tweak T(k) |
| tw_nxt | input | BLK_BYTES*8 | Following tweak T(k+1) |
| tw_adv | output | 1 | Step the tweak generator by one |
| out_valid | output | 1 | Output word valid for one cycle |
| out_data | output | BLK_BYTES*8 | Output word |
| out_be | output | BLK_BYTES | Byte enables for the output word |
| done | output | 1 | High with the last output word |

## Verification
Two things can happen in the same clock cycle. A finished word can be presented on `out_valid` while the next source word is being accepted. The tweak step after the last full block can also coincide with the fetch of the partial word. Both are provoked by runs with an engine that answers at once and a source that keeps `in_valid` high. These are mixed with runs that stall the engine and leave gaps in the source. The outcome is judged by the byte placement of every output, the partial-word enable, the count of tweak steps, and a round trip through a behavioural cipher for every length from 16 to 63.

// File: rtl/xts_cts_pkg.sv
// Shared types for the XTS ciphertext-stealing tail controller.
package xts_cts_pkg;
    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_REQ,
        ST_WAIT,
        ST_PART
    } cts_state_e;
endpackage

// File: rtl/xts_len_split.sv
// Splits a byte length into its count of full blocks and its remainder.
// Assumes BLK_BYTES is a power of two.
module xts_len_split #(
    parameter  int LEN_W     = 16,
    parameter  int BLK_BYTES = 16,
    localparam int OFF_W     = $clog2(BLK_BYTES),
    localparam int CNT_W     = LEN_W - OFF_W
) (
    input  logic [LEN_W-1:0] len,
    output logic [CNT_W-1:0] nfull,
    output logic [OFF_W-1:0] rem,
    output logic             has_tail
);
    // Block count and remainder are plain bit slices of the length.
    always_comb begin
        nfull    = len[LEN_W-1:OFF_W];
        rem      = len[OFF_W-1:0];
        has_tail = (len[OFF_W-1:0] != '0);
    end
endmodule

// File: rtl/xts_tail_merge.sv
// Builds the low-byte keep mask for a remainder and merges the partial
// input bytes over a held block. Assumes rem < BLK_BYTES.
module xts_tail_merge #(
    parameter  int BLK_BYTES = 16,
    localparam int BLK_W     = BLK_BYTES * 8,
    localparam int OFF_W     = $clog2(BLK_BYTES)
) (
    input  logic [OFF_W-1:0]     rem,
    input  logic [BLK_W-1:0]     part,
    input  logic [BLK_W-1:0]     held,
    output logic [BLK_W-1:0]     merged,
    output logic [BLK_BYTES-1:0] keep
);
    for (genvar b = 0; b < BLK_BYTES; b++) begin : g_byte
        // Byte b belongs to the partial data when it lies below the remainder.
        assign keep[b]            = (rem > OFF_W'(b));
        // Partial byte where kept, held byte elsewhere.
        assign merged[8*b +: 8]   = keep[b] ? part[8*b +: 8] : held[8*b +: 8];
    end
endmodule

// File: rtl/xts_cts_ctrl.sv
// XTS message sequencer with ciphertext stealing on a 1..BLK_BYTES-1 byte
// tail. It issues one engine request at a time. Assumes msg_len >= BLK_BYTES,
// a tweak generator that presents T(k) and T(k+1) and steps on tw_adv, and
// an engine that answers every accepted request exactly once.
module xts_cts_ctrl
    import xts_cts_pkg::*;
#(
    parameter  int BLK_BYTES = 16,
    parameter  int LEN_W     = 16,
    localparam int BLK_W     = BLK_BYTES * 8,
    localparam int OFF_W     = $clog2(BLK_BYTES),
    localparam int CNT_W     = LEN_W - OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [LEN_W-1:0]     msg_len,
    input  logic                 decrypt,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [BLK_W-1:0]     in_data,
    output logic                 eng_req,
    input  logic                 eng_req_rdy,
    output logic [BLK_W-1:0]     eng_data,
    output logic [BLK_W-1:0]     eng_tweak,
    output logic                 eng_enc,
    input  logic                 eng_rsp_vld,
    input  logic [BLK_W-1:0]     eng_rsp_data,
    input  logic [BLK_W-1:0]     tw_cur,
    input  logic [BLK_W-1:0]     tw_nxt,
    output logic                 tw_adv,
    output logic                 out_valid,
    output logic [BLK_W-1:0]     out_data,
    output logic [BLK_BYTES-1:0] out_be,
    output logic                 done
);
    cts_state_e           state_q;
    logic                 dec_q, steal_q, tail_q;
    logic [OFF_W-1:0]     rem_q;
    logic [CNT_W-1:0]     left_q;
    logic [BLK_W-1:0]     data_q, hold_q;
    logic                 out_valid_q, done_q, adv_q;
    logic [BLK_W-1:0]     out_data_q;
    logic [BLK_BYTES-1:0] out_be_q;

    logic [CNT_W-1:0]     nfull;
    logic [OFF_W-1:0]     rem;
    logic                 has_tail;
    logic [BLK_W-1:0]     merged;
    logic [BLK_BYTES-1:0] keep;
    logic                 last_body, use_nxt;

    xts_len_split #(.LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)) i_split (
        .len      (msg_len),
        .nfull    (nfull),
        .rem      (rem),
        .has_tail (has_tail)
    );

    xts_tail_merge #(.BLK_BYTES(BLK_BYTES)) i_merge (
        .rem    (rem_q),
        .part   (in_data),
        .held   (hold_q),
        .merged (merged),
        .keep   (keep)
    );

    // Handshake strobes and the tweak choice; decrypt-steal takes the later tweak first.
    always_comb begin
        last_body = (left_q == CNT_W'(1));
        use_nxt   = dec_q && steal_q && last_body && !tail_q;
        in_ready  = (state_q == ST_FETCH);
        eng_req   = (state_q == ST_REQ);
        eng_data  = data_q;
        eng_tweak = use_nxt ? tw_nxt : tw_cur;
        eng_enc   = !dec_q;
        tw_adv    = adv_q;
        out_valid = out_valid_q;
        out_data  = out_data_q;
        out_be    = out_be_q;
        done      = done_q;
    end

    // Message sequencer: body blocks, optional steal step, then the short tail word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            dec_q       <= 1'b0;
            steal_q     <= 1'b0;
            tail_q      <= 1'b0;
            rem_q       <= '0;
            left_q      <= '0;
            data_q      <= '0;
            hold_q      <= '0;
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
            out_be_q    <= '0;
            done_q      <= 1'b0;
            adv_q       <= 1'b0;
        end else begin
            out_valid_q <= 1'b0;
            done_q      <= 1'b0;
            adv_q       <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        dec_q   <= decrypt;
                        rem_q   <= rem;
                        steal_q <= has_tail;
                        left_q  <= nfull;
                        tail_q  <= 1'b0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (in_valid) begin
                        data_q  <= tail_q ? merged : in_data;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (eng_req_rdy) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (eng_rsp_vld) begin
                        if (tail_q) begin
                            out_valid_q <= 1'b1;
                            out_data_q  <= eng_rsp_data;
                            out_be_q    <= '1;
                            state_q     <= ST_PART;
                        end else if (last_body && steal_q) begin
                            hold_q  <= eng_rsp_data;
                            tail_q  <= 1'b1;
                            adv_q   <= !dec_q;
                            state_q <= ST_FETCH;
                        end else begin
                            out_valid_q <= 1'b1;
                            out_data_q  <= eng_rsp_data;
                            out_be_q    <= '1;
                            adv_q       <= 1'b1;
                            left_q      <= left_q - CNT_W'(1);
                            if (last_body) begin
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end else begin
                                state_q <= ST_FETCH;
                            end
                        end
                    end
                end
                ST_PART: begin
                    out_valid_q <= 1'b1;
                    out_data_q  <= hold_q;
                    out_be_q    <= keep;
                    done_q      <= 1'b1;
                    state_q     <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [CNT_W:0]   chk_acc_q;
    logic [CNT_W-1:0] chk_full_q;

    // Counts source words taken since the last accepted start, for R7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_acc_q  <= '0;
            chk_full_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            chk_acc_q  <= '0;
            chk_full_q <= nfull;
        end else if (in_valid && in_ready) begin
            chk_acc_q  <= chk_acc_q + 1'b1;
        end
    end

    p_len_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE) |-> (msg_len >= LEN_W'(BLK_BYTES)));
    p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_req_rdy) |=> !eng_req);
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_req_rdy) |=> (eng_req && $stable(eng_data) && $stable(eng_tweak)));
    p_done_with_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid);
    p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_be != '0) && ((out_be & (out_be + 1'b1)) == '0)));
    p_part_after_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_be != '1) |-> ($past(out_valid) && $past(out_be) == '1 && done));
    p_tail_read_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_be != '1) |-> (chk_acc_q == {1'b0, chk_full_q} + 1'b1));
    p_adv_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tw_adv |-> $past(eng_rsp_vld));
endmodule

// File: tb/test_xts_cts_ctrl.sv
`timescale 1ns/1ps
module test_xts_cts_ctrl;
    localparam int BB = 16;
    localparam int LW = 16;
    localparam int BW = BB * 8;
    localparam logic [BW-1:0] KEY = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start, decrypt, in_valid, in_ready, eng_req, eng_req_rdy, eng_enc;
    logic          eng_rsp_vld, tw_adv, out_valid, done;
    logic [LW-1:0] msg_len;
    logic [BW-1:0] in_data, eng_data, eng_tweak, eng_rsp_data, tw_cur, tw_nxt, out_data;
    logic [BB-1:0] out_be;

    always #10 clk = ~clk;

    xts_cts_ctrl #(.BLK_BYTES(BB), .LEN_W(LW)) i_xts_cts_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len), .decrypt(decrypt),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .eng_req(eng_req), .eng_req_rdy(eng_req_rdy), .eng_data(eng_data),
        .eng_tweak(eng_tweak), .eng_enc(eng_enc), .eng_rsp_vld(eng_rsp_vld),
        .eng_rsp_data(eng_rsp_data), .tw_cur(tw_cur), .tw_nxt(tw_nxt), .tw_adv(tw_adv),
        .out_valid(out_valid), .out_data(out_data), .out_be(out_be), .done(done)
    );

    int checks = 0, errors = 0;
    logic [7:0] msg_b [0:95];
    logic [7:0] ref_b [0:95];
    logic [7:0] src_b [0:95];
    logic [7:0] dst_b [0:95];
    logic run_go = 1'b0, done_seen = 1'b0;
    int mode = 0, k = 0, adv_cnt = 0, out_pos = 0, out_cnt = 0, src_idx = 0;
    int acc_at_part = -1, viol = 0;
    logic [BB-1:0] last_be;

    function automatic logic [BW-1:0] tw(int i);
        return {32'(i) * 32'h9E3779B9 ^ 32'h13579BDF, ~32'(i), 32'(i) ^ 32'hA5A50000, 32'(i) * 7 + 3};
    endfunction
    function automatic logic [BW-1:0] enc_f(logic [BW-1:0] x, logic [BW-1:0] t);
        logic [BW-1:0] y;
        y = x ^ t ^ KEY;
        return {y[BW-9:0], y[BW-1:BW-8]};
    endfunction
    function automatic logic [BW-1:0] dec_f(logic [BW-1:0] y, logic [BW-1:0] t);
        return {y[7:0], y[BW-1:8]} ^ t ^ KEY;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Tweak generator and engine model, both stepped at the falling edge.
    initial begin
        logic          pend;
        int            cnt, cyc;
        logic [BW-1:0] res;
        pend = 1'b0; cnt = 0; cyc = 0;
        eng_req_rdy = 1'b0; eng_rsp_vld = 1'b0; eng_rsp_data = '0;
        tw_cur = tw(0); tw_nxt = tw(1);
        forever begin
            @(negedge clk);
            cyc++;
            if (tw_adv) begin k++; adv_cnt++; end
            tw_cur = tw(k); tw_nxt = tw(k + 1);
            eng_rsp_vld = 1'b0;
            if (pend) begin
                if (cnt == 0) begin eng_rsp_vld = 1'b1; eng_rsp_data = res; pend = 1'b0; end
                else cnt--;
            end
            eng_req_rdy = (mode != 1) || (cyc % 2 == 0);
            if (eng_req && pend) viol++;
            if (eng_req && eng_req_rdy) begin
                res  = eng_enc ? enc_f(eng_data, eng_tweak) : dec_f(eng_data, eng_tweak);
                pend = 1'b1;
                cnt  = (mode == 1) ? 2 : 0;
            end
        end
    end

    // Source model: presents word src_idx, moves on after each acceptance.
    initial begin
        logic acc;
        int   cyc;
        acc = 1'b0; cyc = 0; in_valid = 1'b0; in_data = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!run_go) begin
                src_idx = 0; acc = 1'b0; in_valid = 1'b0;
            end else begin
                if (acc) src_idx++;
                in_valid = (mode != 1) || (cyc % 3 != 0);
                for (int j = 0; j < BB; j++)
                    in_data[8*j +: 8] = (src_idx * BB + j < 96) ? src_b[src_idx * BB + j] : 8'h00;
                acc = in_valid && in_ready;
            end
        end
    end

    // Output collector: places bytes in arrival order.
    initial begin
        forever begin
            @(negedge clk);
            if (out_valid) begin
                for (int j = 0; j < BB; j++)
                    if (out_be[j] && out_pos + j < 96) dst_b[out_pos + j] = out_data[8*j +: 8];
                if (out_be != '1) acc_at_part = src_idx;
                out_pos += $countones(out_be);
                out_cnt++;
                last_be = out_be;
            end
            if (done) done_seen = 1'b1;
        end
    end

    task automatic ref_encrypt(int len);
        int m, r;
        logic [BW-1:0] p, c;
        m = len / BB; r = len % BB;
        for (int i = 0; i < m; i++) begin
            for (int j = 0; j < BB; j++) p[8*j +: 8] = msg_b[i*BB + j];
            c = enc_f(p, tw(i));
            for (int j = 0; j < BB; j++) ref_b[i*BB + j] = c[8*j +: 8];
        end
        if (r != 0) begin
            for (int j = 0; j < BB; j++) c[8*j +: 8] = ref_b[(m-1)*BB + j];
            for (int j = 0; j < r; j++) ref_b[m*BB + j] = c[8*j +: 8];
            for (int j = 0; j < r; j++) c[8*j +: 8] = msg_b[m*BB + j];
            c = enc_f(c, tw(m));
            for (int j = 0; j < BB; j++) ref_b[(m-1)*BB + j] = c[8*j +: 8];
        end
    endtask

    task automatic run(int len, logic dec, output int accepted);
        @(negedge clk);
        out_pos = 0; out_cnt = 0; adv_cnt = 0; k = 0; done_seen = 1'b0; acc_at_part = -1;
        for (int j = 0; j < 96; j++) dst_b[j] = 8'h5A;
        msg_len = LW'(len); decrypt = dec; start = 1'b1; run_go = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mode == 2) begin
            @(negedge clk);
            msg_len = LW'(17); decrypt = !dec; start = 1'b1;
            @(negedge clk);
            start = 1'b0; msg_len = LW'(len); decrypt = dec;
        end
        for (int c = 0; c < 3000 && !done_seen; c++) @(negedge clk);
        if (!done_seen) chk(1'b0, "R3 watchdog", 0, 1);
        @(negedge clk);
        accepted = src_idx;
        run_go = 1'b0;
    endtask

    task automatic verify(int len, logic dec, int accepted, string bytes_tag);
        int m, r, bad, exp_adv;
        m = len / BB; r = len % BB; bad = -1;
        for (int j = len - 1; j >= 0; j--)
            if (dst_b[j] !== (dec ? msg_b[j] : ref_b[j])) bad = j;
        chk(bad < 0, bytes_tag, (bad < 0) ? 0 : dst_b[bad], (bad < 0) ? 0 : (dec ? msg_b[bad] : ref_b[bad]));
        if (mode == 2) chk(bad < 0, "R9 stray start", bad, -1);
        chk(accepted == m + (r != 0 ? 1 : 0), "R1 words taken", accepted, m + (r != 0 ? 1 : 0));
        chk(out_cnt == m + (r != 0 ? 1 : 0), (r != 0) ? "R6 output count" : "R3 output count",
            out_cnt, m + (r != 0 ? 1 : 0));
        exp_adv = (dec && r != 0) ? m - 1 : m;
        chk(adv_cnt == exp_adv, "R8 tweak steps", adv_cnt, exp_adv);
        if (r != 0) begin
            chk(last_be == BB'((1 << r) - 1), "R6 partial enables", last_be, (1 << r) - 1);
            chk(acc_at_part == m + 1, "R7 read before write", acc_at_part, m + 1);
        end
        chk(viol == 0, "R2 one outstanding", viol, 0);
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int acc;
        start = 1'b0; msg_len = '0; decrypt = 1'b0;
        repeat (3) @(negedge clk);
        chk({in_ready, eng_req, out_valid, done, tw_adv} == 5'b0, "R10 in reset",
            {in_ready, eng_req, out_valid, done, tw_adv}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({in_ready, eng_req, out_valid, done, tw_adv} == 5'b0, "R10 after reset",
            {in_ready, eng_req, out_valid, done, tw_adv}, 0);
        for (int len = 16; len < 64; len++) begin
            mode = len % 3;
            for (int j = 0; j < 96; j++) msg_b[j] = 8'((len * 37 + j * 11 + 5) & 255);
            ref_encrypt(len);
            for (int j = 0; j < 96; j++) src_b[j] = (j < len) ? msg_b[j] : (8'hEE ^ 8'(j));
            run(len, 1'b0, acc);
            verify(len, 1'b0, acc, (len % BB != 0) ? "R4 encrypt steal" : "R3 encrypt blocks");
            for (int j = 0; j < 96; j++) src_b[j] = (j < len) ? dst_b[j] : (8'hC3 ^ 8'(j));
            run(len, 1'b1, acc);
            verify(len, 1'b1, acc, (len % BB != 0) ? "R5 decrypt round trip" : "R3 decrypt round trip");
        end
        chk(!in_ready && !eng_req, "R1 idle after runs", {in_ready, eng_req}, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule